// File: doc/BRIEF.md
# Ethernet MAC Network Control Register

This block holds the 8-bit control word of an Ethernet media access controller. Software writes it and reads it back through a simple register port. The block turns the stored bits into the enable levels for the receiver, the transmitter and the MII management logic. It also turns them into the PHY-path select, loopback and duplex levels.

Each bit has its own write rule. The PHY-path select bit latches only the first write after any reset. A low-power wait input can gate the whole controller off, management included, when the wait-disable bit is set.

Two events make the block emit single-cycle side-effect pulses that abort a reception in progress and clear the PAUSE timeout:
- the MAC being switched off;
- wait gating taking hold.

The block watches transmit-active and management-busy status. It raises a violation pulse when software changes a bit at a moment it must not.

Top module: `emac_netctl_reg`

## Requirements
- R1: After hardware reset (`rst_n` low) or software reset (`soft_rst` high at a clock edge), the stored word reads 0x00. `rx_enable` and `tx_enable` are 0, `mgmt_enable` is 1, and `int_phy_sel` is 1.
- R2: Bit layout: enable is bit 7, wait-disable is bit 5, external PHY is bit 4, loopback is bit 3 and full duplex is bit 1. Bits 6, 2 and 0 ignore writes and read as 0.
- R3: While enable is 1 and wait gating is inactive, `rx_enable` and `tx_enable` are 1. A write that clears enable drops both in the cycle after the write edge.
- R4: `mgmt_enable` does not depend on the enable bit. It is 0 only while wait-disable is 1 and `wait_mode` is 1.
- R5: While wait-disable is 1 and `wait_mode` is 1, `rx_enable`, `tx_enable` and `mgmt_enable` are all 0. While wait-disable is 0, `wait_mode` has no effect on them.
- R6: A write that changes enable from 1 to 0 makes `drop_rx` and `clear_pause` high for exactly one cycle, namely the cycle after the write edge.
- R7: When wait gating becomes active (wait-disable and `wait_mode` both 1, after they were not both 1 at the previous edge), `drop_rx` and `clear_pause` are high in that cycle only.
- R8: The external-PHY bit takes the value of the first write after a reset. Later writes leave it unchanged until the next hardware or software reset.
- R9: `ext_phy_sel` equals the external-PHY bit and `int_phy_sel` is its inverse. `loopback` follows bit 3 and `full_duplex` follows bit 1.
- R10: `proto_err` is high for one cycle after a write edge in any of these cases. The write still takes effect.
  - The write changes enable while `tx_active` is 1.
  - The write changes a still-writable external-PHY bit while enable or `mgmt_busy` is 1.
  - The write raises enable from 0 to 1 and in the same write changes loopback or a writable external-PHY bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| soft_rst | input | 1 | Synchronous software reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read data, valid at any time |
| wait_mode | input | 1 | Device is in low-power wait mode |
| tx_active | input | 1 | Transmitter is sending a frame |
| mgmt_busy | input | 1 | Management transfer in progress |
| rx_enable | output | 1 | Receiver permitted |
| tx_enable | output | 1 | Transmitter permitted |
| mgmt_enable | output | 1 | MII management logic permitted |
| ext_phy_sel | output | 1 | MII pins routed to an external PHY |
| int_phy_sel | output | 1 | MII connected to the internal PHY |
| loopback | output | 1 | MAC loopback |
| full_duplex | output | 1 | Full-duplex operation |
| drop_rx | output | 1 | Pulse: abort reception in progress |
| clear_pause | output | 1 | Pulse: clear PAUSE timeout |
| proto_err | output | 1 | Pulse: software write-rule violation |

## Verification
The bench attacks the write-once lock in four ways:
- a second write after the first;
- a write that sets the bit after the first write stored a 0;
- a software reset followed by a new first write;
- the case where the lock never re-arms, which a faulty design would show by leaving the PHY path stuck.

It checks that gating in wait mode also turns management off, while disabling the MAC does not, since a swapped gate would stall management transfers during normal disable. It times the abort and clear pulses to the exact cycle and confirms they end after one cycle; a level instead of a pulse would kill every later reception. Violation detection is probed with a risky enable change during transmit, with enable and loopback set in one write, and with a harmless write that must not flag.

// File: rtl/emac_netctl_reg.sv
module emac_netctl_reg (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       wait_mode,
  input  logic       tx_active,
  input  logic       mgmt_busy,
  output logic       rx_enable,
  output logic       tx_enable,
  output logic       mgmt_enable,
  output logic       ext_phy_sel,
  output logic       int_phy_sel,
  output logic       loopback,
  output logic       full_duplex,
  output logic       drop_rx,
  output logic       clear_pause,
  output logic       proto_err
);
  localparam int B_EN = 7, B_WD = 5, B_XP = 4, B_LB = 3, B_FD = 1;

  logic mac_on, wait_off, xphy, lpbk, fdx;
  logic xphy_lock, mac_on_q, gated_q, err_q;

  logic gated, xphy_chg, en_chg, lb_chg;
  assign gated    = wait_off & wait_mode;
  assign en_chg   = wr_data[B_EN] != mac_on;
  assign lb_chg   = wr_data[B_LB] != lpbk;
  assign xphy_chg = !xphy_lock && (wr_data[B_XP] != xphy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mac_on <= 1'b0; wait_off <= 1'b0; xphy <= 1'b0; lpbk <= 1'b0; fdx <= 1'b0;
      xphy_lock <= 1'b0; mac_on_q <= 1'b0; gated_q <= 1'b0; err_q <= 1'b0;
    end else if (soft_rst) begin
      mac_on <= 1'b0; wait_off <= 1'b0; xphy <= 1'b0; lpbk <= 1'b0; fdx <= 1'b0;
      xphy_lock <= 1'b0; mac_on_q <= 1'b0; gated_q <= 1'b0; err_q <= 1'b0;
    end else begin
      mac_on_q <= mac_on;
      gated_q  <= gated;
      err_q    <= wr_en && ((en_chg && tx_active) ||
                            (xphy_chg && (mac_on || mgmt_busy)) ||
                            (wr_data[B_EN] && !mac_on && (lb_chg || xphy_chg)));
      if (wr_en) begin
        mac_on    <= wr_data[B_EN];
        wait_off  <= wr_data[B_WD];
        lpbk      <= wr_data[B_LB];
        fdx       <= wr_data[B_FD];
        xphy_lock <= 1'b1;
        if (!xphy_lock) xphy <= wr_data[B_XP];
      end
    end
  end

  assign rd_data     = {mac_on, 1'b0, wait_off, xphy, lpbk, 1'b0, fdx, 1'b0};
  assign rx_enable   = mac_on & ~gated;
  assign tx_enable   = mac_on & ~gated;
  assign mgmt_enable = ~gated;
  assign ext_phy_sel = xphy;
  assign int_phy_sel = ~xphy;
  assign loopback    = lpbk;
  assign full_duplex = fdx;
  assign drop_rx     = (mac_on_q & ~mac_on) | (gated & ~gated_q);
  assign clear_pause = drop_rx;
  assign proto_err   = err_q;

  // R1
  soft_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (rd_data == 8'h00));
  // R8
  xphy_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xphy_lock && !soft_rst) |=> $stable(ext_phy_sel));
  // R6
  disable_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst && rd_data[B_EN] && !wr_data[B_EN]) |=> (drop_rx && clear_pause));
  // R7
  wait_entry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[B_WD] && $rose(wait_mode) && $stable(rd_data)) |-> clear_pause);
  // R4
  mgmt_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wait_mode |-> mgmt_enable);
  // R10
  tx_active_violation_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !soft_rst && tx_active && (wr_data[B_EN] != rd_data[B_EN])) |=> proto_err);
endmodule

// File: tb/sim_emac_netctl_reg.sv
module sim_emac_netctl_reg;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic wait_mode = 1'b0, tx_active = 1'b0, mgmt_busy = 1'b0;
  logic [7:0] rd_data;
  logic rx_enable, tx_enable, mgmt_enable, ext_phy_sel, int_phy_sel;
  logic loopback, full_duplex, drop_rx, clear_pause, proto_err;
  int checks = 0, errors = 0;

  always #(PERIOD/2) clk = ~clk;

  emac_netctl_reg u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .wait_mode(wait_mode), .tx_active(tx_active), .mgmt_busy(mgmt_busy),
    .rx_enable(rx_enable), .tx_enable(tx_enable), .mgmt_enable(mgmt_enable),
    .ext_phy_sel(ext_phy_sel), .int_phy_sel(int_phy_sel), .loopback(loopback),
    .full_duplex(full_duplex), .drop_rx(drop_rx), .clear_pause(clear_pause),
    .proto_err(proto_err)
  );

  // {write data, wait_mode, expected readback, expected rx/tx, expected mgmt}
  localparam logic [18:0] VEC [6] = '{
    {8'h4F, 1'b0, 8'h0A, 1'b0, 1'b1},
    {8'h8A, 1'b0, 8'h8A, 1'b1, 1'b1},
    {8'hBA, 1'b0, 8'hAA, 1'b1, 1'b1},
    {8'hAA, 1'b1, 8'hAA, 1'b0, 1'b0},
    {8'h8A, 1'b1, 8'h8A, 1'b1, 1'b1},
    {8'h02, 1'b0, 8'h02, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic write(input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic sreset();
    @(negedge clk); soft_rst = 1'b1;
    @(negedge clk); soft_rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 5000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 hardware reset state
    check("R1 rd", rd_data, 8'h00);
    check("R1 en", {rx_enable, tx_enable, mgmt_enable, int_phy_sel}, 4'b0011);

    for (int i = 0; i < 6; i++) begin
      wait_mode = VEC[i][10];
      write(VEC[i][18:11]);
      // R2 R3 R5 R8 readback and gating
      check("R2/R5 rd", rd_data, VEC[i][9:2]);
      check("R3/R5 rx", {rx_enable, tx_enable}, {2{VEC[i][1]}});
      check("R4/R5 mgmt", mgmt_enable, VEC[i][0]);
    end
    wait_mode = 1'b0;
    // R9 loopback/duplex levels from last vector (0x02)
    check("R9 lb/fd", {loopback, full_duplex}, 2'b01);

    // R1 software reset, R8 re-arm
    sreset();
    check("R1 soft rd", rd_data, 8'h00);
    write(8'h10);
    check("R8 first", rd_data, 8'h10);
    check("R9 phy", {ext_phy_sel, int_phy_sel}, 2'b10);
    write(8'h00);
    check("R8 locked", rd_data, 8'h10);

    // R6 disable pulse
    write(8'h90);
    check("R4 mgmt with en", mgmt_enable, 1'b1);
    @(negedge clk); wr_en = 1'b1; wr_data = 8'h10;
    @(negedge clk); wr_en = 1'b0;
    check("R6 pulse", {drop_rx, clear_pause}, 2'b11);
    check("R3 off", {rx_enable, tx_enable}, 2'b00);
    @(negedge clk);
    check("R6 one cycle", {drop_rx, clear_pause}, 2'b00);

    // R7 wait entry pulse
    write(8'h30);
    @(negedge clk); wait_mode = 1'b1;
    #1 check("R7 pulse", {drop_rx, clear_pause}, 2'b11);
    check("R5 mgmt gated", mgmt_enable, 1'b0);
    @(negedge clk);
    check("R7 one cycle", {drop_rx, clear_pause}, 2'b00);
    wait_mode = 1'b0;

    // R10 violations
    tx_active = 1'b1;
    write(8'h90);
    check("R10 tx_active", proto_err, 1'b1);
    tx_active = 1'b0;
    write(8'h98);
    check("R10 benign", proto_err, 1'b0);
    sreset();
    write(8'h88);
    check("R10 en+lb", proto_err, 1'b1);
    @(negedge clk);
    check("R10 one cycle", proto_err, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule